// File: doc/BRIEF.md
# Two-Lane Shift-Mask-Add Interpolator

This block is a register-mapped arithmetic helper for tight software loops that walk tables or pack and unpack bit fields. It holds two lanes. Each lane has a 32-bit accumulator, a base value and a control word. A lane takes its accumulator, shifts it right, keeps an inclusive bit field, can sign-extend that field, and adds its own base to form the lane result. A third base is shared by both lanes. The full result is that shared base plus the two raw lane values.

Software reads results in two ways. A peek read has no side effect. A pop read returns the same value and, on the same clock edge, loads each lane's result back into that lane's accumulator, so a loop advances with one read per step. Two add aliases atomically increment an accumulator. A combined base write loads the low half of the word into lane 0's base and the high half into lane 1's base in one cycle.

The block has separate write and read ports, and both can be used in the same cycle. Read data is combinational from the current state. There is no back-pressure: every access completes in the cycle in which it is presented, so the ports carry plain enables and have no valid/ready pair.

Top module: `interp_core`

## Requirements
- R1: After reset, all accumulators, bases and control words are zero, so every read returns 0.
- R2: The following word addresses are readable and writable directly: accumulator 0 and 1 (0, 1), base 0 and 1 (2, 3), control 0 and 1 (4, 5) and the shared base (8). A control word keeps bits 15:0 and reads back zero-extended.
- R3: Control word fields are: shift amount in bits 4:0, field low bit in bits 9:5, field high bit in bits 14:10. The raw value is (acc >> shift) with only bits low..high kept. If high < low, the raw value is 0.
- R4: When control bit 15 (signed) is set, the raw field is sign-extended from its high bit.
- R5: The lane result is raw + base, modulo 2^32. A peek read returns it for lane 0 at address 10 and for lane 1 at address 11.
- R6: A read of the full result (peek 12, pop 15) returns shared base + raw0 + raw1, modulo 2^32.
- R7: Peek reads (10, 11, 12) change no state.
- R8: Pop reads (13 = lane 0, 14 = lane 1, 15 = full) return the same value as the matching peek and load each lane's result into its own accumulator on that clock edge.
- R9: A write to the add alias of a lane (6 = lane 0, 7 = lane 1) adds the written data to that accumulator. A read of the alias returns that lane's raw value, without the base.
- R10: A write to address 9 loads data bits 15:0 into base 0 and bits 31:16 into base 1 in the same cycle. Each half is sign-extended when that lane's signed bit is set and zero-extended otherwise.
- R11: If a bus write to an accumulator or its add alias occurs in the same cycle as a pop, the write decides that accumulator. The other lane is still popped.
- R12: A read of address 9 returns 0. Writes to the result addresses (10 to 15) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a pop address also updates the accumulators on the clock edge |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational; 0 when rd_en is low |

## Verification
The hardest case to reach is a pop that coincides with a bus write to one accumulator: lane 0 must take the written value while lane 1 still takes its popped result. A single shared bus cannot create this case. The bench reaches it by driving both strobes in the same cycle from a dedicated task, and then reads both accumulators back. Sign extension in the combined base write depends on control state that is set earlier, so the bench first gives the two lanes opposite signed flags and then writes negative halves into both.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int ADDR_W = 4;
  // word addresses; lane 1 variants sit at lane 0 address + 1
  localparam logic [ADDR_W-1:0] A_ACC0      = 4'd0;
  localparam logic [ADDR_W-1:0] A_BASE0     = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTRL0     = 4'd4;
  localparam logic [ADDR_W-1:0] A_ADD0      = 4'd6;
  localparam logic [ADDR_W-1:0] A_BASE2     = 4'd8;
  localparam logic [ADDR_W-1:0] A_BASE_BOTH = 4'd9;
  localparam logic [ADDR_W-1:0] A_PEEK0     = 4'd10;
  localparam logic [ADDR_W-1:0] A_PEEK_FULL = 4'd12;
  localparam logic [ADDR_W-1:0] A_POP0      = 4'd13;
  localparam logic [ADDR_W-1:0] A_POP_FULL  = 4'd15;
  localparam int NUM_LANES = 2;
endpackage

// File: rtl/interp_lane.sv
module interp_lane #(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = 5
) (
  input  logic [DATA_W-1:0]  acc,
  input  logic [DATA_W-1:0]  base,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [SHIFT_W-1:0] lsb,
  input  logic [SHIFT_W-1:0] msb,
  input  logic               sgn,
  output logic [DATA_W-1:0]  raw,
  output logic [DATA_W-1:0]  result
);
  logic [DATA_W-1:0] shifted, mask, masked, upper;
  logic              top_bit;

  assign shifted = acc >> shift;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mask[i]  = (i >= int'(lsb)) && (i <= int'(msb));
      upper[i] = (i > int'(msb));
    end
  end

  assign masked  = shifted & mask;
  assign top_bit = sgn && masked[msb];
  assign raw     = top_bit ? (masked | upper) : masked;
  assign result  = raw + base;
endmodule

// File: rtl/interp_core.sv
module interp_core
  import interp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [3:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SHIFT_W = $clog2(DATA_W);
  localparam int CTRL_W  = 3 * SHIFT_W + 1;
  localparam int HALF_W  = DATA_W / 2;

  logic [NUM_LANES-1:0][DATA_W-1:0] acc_q, base_q, raw, res;
  logic [NUM_LANES-1:0][CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0]                base2_q, full;
  logic                             pop;

  assign pop  = rd_en && (rd_addr >= A_POP0);
  assign full = base2_q + raw[0] + raw[1];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [HALF_W-1:0] half;
    logic [DATA_W-1:0] half_ext;
    logic              lane_sgn;

    assign lane_sgn = ctrl_q[g][3*SHIFT_W];
    assign half     = wr_data[g*HALF_W +: HALF_W];
    assign half_ext = lane_sgn ? {{HALF_W{half[HALF_W-1]}}, half}
                               : {{HALF_W{1'b0}}, half};

    interp_lane #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_lane (
      .acc    (acc_q[g]),
      .base   (base_q[g]),
      .shift  (ctrl_q[g][SHIFT_W-1:0]),
      .lsb    (ctrl_q[g][2*SHIFT_W-1:SHIFT_W]),
      .msb    (ctrl_q[g][3*SHIFT_W-1:2*SHIFT_W]),
      .sgn    (lane_sgn),
      .raw    (raw[g]),
      .result (res[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[g]  <= '0;
        base_q[g] <= '0;
        ctrl_q[g] <= '0;
      end else begin
        // bus write to the accumulator wins over a pop
        if (wr_en && wr_addr == A_ACC0 + 4'(g))
          acc_q[g] <= wr_data;
        else if (wr_en && wr_addr == A_ADD0 + 4'(g))
          acc_q[g] <= acc_q[g] + wr_data;
        else if (pop)
          acc_q[g] <= res[g];

        if (wr_en && wr_addr == A_BASE0 + 4'(g))
          base_q[g] <= wr_data;
        else if (wr_en && wr_addr == A_BASE_BOTH)
          base_q[g] <= half_ext;

        if (wr_en && wr_addr == A_CTRL0 + 4'(g))
          ctrl_q[g] <= wr_data[CTRL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      base2_q <= '0;
    else if (wr_en && wr_addr == A_BASE2)
      base2_q <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        4'd0:    rd_data = acc_q[0];
        4'd1:    rd_data = acc_q[1];
        4'd2:    rd_data = base_q[0];
        4'd3:    rd_data = base_q[1];
        4'd4:    rd_data = DATA_W'(ctrl_q[0]);
        4'd5:    rd_data = DATA_W'(ctrl_q[1]);
        4'd6:    rd_data = raw[0];
        4'd7:    rd_data = raw[1];
        4'd8:    rd_data = base2_q;
        4'd10,
        4'd13:   rd_data = res[0];
        4'd11,
        4'd14:   rd_data = res[1];
        4'd12,
        4'd15:   rd_data = full;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/interp_core_chk.sv
module interp_core_chk
  import interp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic [3:0]                       wr_addr,
  input logic [DATA_W-1:0]                wr_data,
  input logic                             rd_en,
  input logic [3:0]                       rd_addr,
  input logic [DATA_W-1:0]                rd_data,
  input logic [NUM_LANES-1:0][DATA_W-1:0] acc_q,
  input logic [NUM_LANES-1:0][DATA_W-1:0] base_q,
  input logic [NUM_LANES-1:0][DATA_W-1:0] res,
  input logic [DATA_W-1:0]                base2_q
);
  localparam int HALF_W = DATA_W / 2;

  assert_peek_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr >= A_PEEK0 && rd_addr <= A_PEEK_FULL && !wr_en) |=> $stable(acc_q));

  assert_pop_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr >= A_POP0 && !wr_en) |=>
      (acc_q[0] == $past(res[0]) && acc_q[1] == $past(res[1])));

  assert_add_alias_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ADD0) |=> acc_q[0] == $past(acc_q[0]) + $past(wr_data));

  assert_both_bases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_BASE_BOTH) |=>
      (base_q[0][HALF_W-1:0] == $past(wr_data[HALF_W-1:0]) &&
       base_q[1][HALF_W-1:0] == $past(wr_data[DATA_W-1:HALF_W])));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ACC0) |=> acc_q[0] == $past(wr_data));

  assert_full_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_PEEK_FULL) |->
      rd_data == base2_q + (res[0] - base_q[0]) + (res[1] - base_q[1]));
endmodule

bind interp_core interp_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .acc_q(acc_q),
  .base_q(base_q), .res(res), .base2_q(base2_q)
);

// File: tb/interp_core_test.sv
module interp_core_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;

  interp_core uut (.*);

  always #2 clk = ~clk;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: expected completion, actual timeout");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] mkc(int sh, int lo, int hi, bit sg);
    return {16'b0, sg, 5'(hi), 5'(lo), 5'(sh)};
  endfunction

  function automatic logic [31:0] m_raw(logic [31:0] acc, logic [31:0] c);
    int sh = int'(c[4:0]);
    int lo = int'(c[9:5]);
    int hi = int'(c[14:10]);
    logic [63:0] v, r;
    if (hi < lo) return 32'h0;
    v = {32'b0, acc} >> sh;
    r = ((v >> lo) & ((64'd1 << (hi - lo + 1)) - 1)) << lo;
    if (c[15] && r[hi]) r = r | ~((64'd1 << (hi + 1)) - 1);
    return r[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_en = 1; rd_addr = a;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reset read", d, 32'h0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'd0, 32'hDEADBEEF); rd(4'd0, d); chk("R2 acc0", d, 32'hDEADBEEF);
    wr(4'd1, 32'h01234567); rd(4'd1, d); chk("R2 acc1", d, 32'h01234567);
    wr(4'd2, 32'hA5A5A5A5); rd(4'd2, d); chk("R2 base0", d, 32'hA5A5A5A5);
    wr(4'd3, 32'h5A5A5A5A); rd(4'd3, d); chk("R2 base1", d, 32'h5A5A5A5A);
    wr(4'd8, 32'hCAFEF00D); rd(4'd8, d); chk("R2 base2", d, 32'hCAFEF00D);
    wr(4'd4, 32'hFFFFFFFF); rd(4'd4, d); chk("R2 ctrl0 width", d, 32'h0000FFFF);
    wr(4'd5, 32'h00001234); rd(4'd5, d); chk("R2 ctrl1", d, 32'h00001234);
  endtask

  task automatic t_unsigned;
    logic [31:0] d, c;
    c = mkc(4, 2, 9, 0);
    wr(4'd0, 32'h12345678); wr(4'd4, c); wr(4'd2, 32'd100);
    rd(4'd6, d);  chk("R3 raw lane0", d, m_raw(32'h12345678, c));
    rd(4'd10, d); chk("R5 peek lane0", d, m_raw(32'h12345678, c) + 32'd100);
    c = mkc(0, 9, 3, 0);
    wr(4'd4, c);
    rd(4'd10, d); chk("R3 empty field", d, 32'd100);
    c = mkc(31, 0, 31, 0);
    wr(4'd1, 32'h80000000); wr(4'd5, c); wr(4'd3, 32'd7);
    rd(4'd11, d); chk("R5 peek lane1 max shift", d, 32'd8);
  endtask

  task automatic t_signed;
    logic [31:0] d, c;
    c = mkc(8, 0, 7, 1);
    wr(4'd0, 32'h0000F300); wr(4'd4, c); wr(4'd2, 32'd0);
    rd(4'd6, d);  chk("R4 sign extend neg", d, 32'hFFFFFFF3);
    wr(4'd0, 32'h00007300);
    rd(4'd6, d);  chk("R4 sign extend pos", d, 32'h00000073);
    c = mkc(0, 4, 11, 1);
    wr(4'd0, 32'h00000F50); wr(4'd4, c); wr(4'd2, 32'd16);
    rd(4'd10, d); chk("R4 mid field signed", d, m_raw(32'h00000F50, c) + 32'd16);
  endtask

  task automatic t_full;
    logic [31:0] d, c0, c1;
    c0 = mkc(0, 0, 31, 0); c1 = mkc(4, 0, 15, 0);
    wr(4'd4, c0); wr(4'd5, c1);
    wr(4'd0, 32'h00000020); wr(4'd1, 32'h00ABCDE0);
    wr(4'd8, 32'hFFFFFFF0);
    rd(4'd12, d);
    chk("R6 full wraps", d, 32'hFFFFFFF0 + 32'h20 + m_raw(32'h00ABCDE0, c1));
  endtask

  task automatic t_peek;
    logic [31:0] d;
    wr(4'd0, 32'h11); wr(4'd1, 32'h22);
    rd(4'd10, d); rd(4'd11, d); rd(4'd12, d);
    rd(4'd0, d); chk("R7 acc0 after peeks", d, 32'h11);
    rd(4'd1, d); chk("R7 acc1 after peeks", d, 32'h22);
  endtask

  task automatic t_pop;
    logic [31:0] d, c;
    c = mkc(0, 0, 31, 0);
    wr(4'd4, c); wr(4'd5, c);
    wr(4'd0, 32'd10); wr(4'd1, 32'd50);
    wr(4'd2, 32'd3);  wr(4'd3, 32'd5); wr(4'd8, 32'd1000);
    rd(4'd13, d); chk("R8 pop lane0 value", d, 32'd13);
    rd(4'd0, d);  chk("R8 acc0 after pop", d, 32'd13);
    rd(4'd1, d);  chk("R8 acc1 after pop", d, 32'd55);
    rd(4'd15, d); chk("R8 pop full value", d, 32'd1068);
    rd(4'd0, d);  chk("R8 acc0 after pop full", d, 32'd16);
    rd(4'd14, d); chk("R8 pop lane1 value", d, 32'd65);
    rd(4'd1, d);  chk("R8 acc1 after pop lane1", d, 32'd65);
  endtask

  task automatic t_add;
    logic [31:0] d, c;
    c = mkc(1, 0, 3, 0);
    wr(4'd4, c); wr(4'd2, 32'd1000);
    wr(4'd0, 32'd20);
    wr(4'd6, 32'd5);
    rd(4'd0, d); chk("R9 add alias lane0", d, 32'd25);
    rd(4'd6, d); chk("R9 alias read raw", d, m_raw(32'd25, c));
    wr(4'd1, 32'hFFFFFFFF);
    wr(4'd7, 32'd2);
    rd(4'd1, d); chk("R9 add alias lane1 wrap", d, 32'd1);
  endtask

  task automatic t_both;
    logic [31:0] d;
    wr(4'd4, mkc(0, 0, 31, 1)); wr(4'd5, mkc(0, 0, 31, 0));
    wr(4'd9, 32'h80018002);
    rd(4'd2, d); chk("R10 base0 signed half", d, 32'hFFFF8002);
    rd(4'd3, d); chk("R10 base1 unsigned half", d, 32'h00008001);
    rd(4'd9, d); chk("R12 base-both reads zero", d, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] d, c;
    c = mkc(0, 0, 31, 0);
    wr(4'd4, c); wr(4'd5, c);
    wr(4'd2, 32'd1); wr(4'd3, 32'd2); wr(4'd8, 32'd0);
    wr(4'd0, 32'h100); wr(4'd1, 32'h200);
    wr_en = 1; wr_addr = 4'd0; wr_data = 32'hAAAA;
    rd_en = 1; rd_addr = 4'd15;
    #1 d = rd_data;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
    chk("R11 pop data during write", d, 32'h300);
    rd(4'd0, d); chk("R11 write wins lane0", d, 32'hAAAA);
    rd(4'd1, d); chk("R11 lane1 still popped", d, 32'h202);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(4'd0, 32'h77); wr(4'd1, 32'h88);
    for (int a = 10; a < 16; a++) wr(4'(a), 32'h12345678);
    rd(4'd0, d); chk("R12 result write ignored acc0", d, 32'h77);
    rd(4'd1, d); chk("R12 result write ignored acc1", d, 32'h88);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_regs;
    t_unsigned;
    t_signed;
    t_full;
    t_peek;
    t_pop;
    t_add;
    t_both;
    t_priority;
    t_ignored;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule